// File: doc/BRIEF.md
# Chip Select and Wait-State Generator

This block turns the top byte of a 24-bit address into one of four active-low chip-select strobes. It also paces the bus cycle through an active-low wait output. Each select owns three byte-wide registers: an inclusive lower bound, an inclusive upper bound and a control byte. The control byte enables the select, sets whether it answers memory or I/O cycles, and sets a wait count from 0 to 7 clocks.

A processor-side bus presents `bus_req` for the whole of each access, with `bus_io` giving the cycle type and `bus_page` carrying address bits 23:16. Consecutive accesses are separated by at least one idle clock. When several enabled windows cover the same page, only the lowest-numbered select fires. The wait output is held low from the first clock of the access for exactly the programmed number of clocks. Software sets up the windows through a small write port with a combinational read-back path.

Top module: `csel_wait_gen`

## Requirements
- R1: After reset, select 0 reads lower 00h, upper FFh and control E8h. Selects 1 to 3 read 00h in all three registers.
- R2: `cfg_idx[3:2]` names the select and `cfg_idx[1:0]` names the register: 0 lower bound, 1 upper bound, 2 control. Code 3 always reads 00h and ignores writes. A write lands on the next rising clock edge, and `cfg_rdata` follows `cfg_idx` combinationally.
- R3: The control byte holds the wait count in bits 7:5, the type in bit 4 (1 = I/O, 0 = memory) and the enable in bit 3. Bits 2:0 read as zero whatever is written.
- R4: A window matches when lower ≤ `bus_page` ≤ upper, and both ends are inclusive.
- R5: A select fires only when it is enabled and its type bit equals `bus_io`. A disabled select never fires.
- R6: When several selects match, only the lowest-numbered one is driven low.
- R7: `cs_n` is active low and is driven only while `bus_req` is high. It follows the inputs within the same cycle.
- R8: With wait count N, `wait_n` is low in clocks 0 to N-1 of the access, counting the first clock of `bus_req` as clock 0, and high afterwards. N = 0 never drives it low.
- R9: Once released within an access, `wait_n` stays high. Dropping `bus_req` releases it at once, and the next access starts a fresh count.
- R10: An access that matches no select drives neither a select nor a wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index: select number and register kind |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data |
| bus_req | input | 1 | Bus access in progress |
| bus_io | input | 1 | Access type: 1 = I/O, 0 = memory |
| bus_page | input | 8 | Address bits 23:16 |
| cs_n | output | 4 | Active-low chip selects |
| wait_n | output | 1 | Active-low wait request |

## Verification
The bench probes pages that sit exactly on a lower or an upper bound. An off-by-one comparator would drop the select on those edges. It also sends accesses of the wrong type and accesses to a disabled window, where a decoder that skips the type or enable term would fire a select. Overlapping windows are hit at several pages; a wrong priority encoder would drive two strobes or the higher-numbered one. Every wait count from 0 to 7 is timed clock by clock, and one access is abandoned mid-wait. A counter that is off by one, that asserts for a zero count, or that keeps a stale count into the next access would show a wrong wait length.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam int WAIT_W  = 3;
    localparam int WAIT_LSB = 5;
    localparam int IO_BIT  = 4;
    localparam int EN_BIT  = 3;
    localparam logic [7:0] CTL_KEEP = 8'hF8;

    typedef enum logic [1:0] {
        RK_LOWER = 2'd0,
        RK_UPPER = 2'd1,
        RK_CTRL  = 2'd2,
        RK_PAD   = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic              req;
        logic [WAIT_W-1:0] cnt;
    } wctr_t;

    function automatic logic [7:0] upper_rst(input int idx);
        return (idx == 0) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic [7:0] ctrl_rst(input int idx);
        return (idx == 0) ? 8'hE8 : 8'h00;
    endfunction

endpackage

// File: rtl/csw_regfile.sv
module csw_regfile
    import csw_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DW     = 8,
    localparam int CSW   = $clog2(NUM_CS),
    localparam int IDX_W = CSW + 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [DW-1:0]                 cfg_wdata,
    output logic [DW-1:0]                 cfg_rdata,
    output logic [NUM_CS-1:0][DW-1:0]     lo_bound,
    output logic [NUM_CS-1:0][DW-1:0]     hi_bound,
    output logic [NUM_CS-1:0]             cs_en,
    output logic [NUM_CS-1:0]             cs_io,
    output logic [NUM_CS-1:0][WAIT_W-1:0] cs_wait
);

    logic [NUM_CS-1:0][DW-1:0] lo_d, lo_q;
    logic [NUM_CS-1:0][DW-1:0] hi_d, hi_q;
    logic [NUM_CS-1:0][DW-1:0] ctl_d, ctl_q;
    logic [CSW-1:0]            cs_num;
    reg_kind_e                 kind;

    assign cs_num = cfg_idx[IDX_W-1:2];
    assign kind   = reg_kind_e'(cfg_idx[1:0]);

    always_comb begin
        lo_d  = lo_q;
        hi_d  = hi_q;
        ctl_d = ctl_q;
        if (cfg_we) begin
            case (kind)
                RK_LOWER: lo_d[cs_num]  = cfg_wdata;
                RK_UPPER: hi_d[cs_num]  = cfg_wdata;
                RK_CTRL:  ctl_d[cs_num] = cfg_wdata & CTL_KEEP;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CS; i++) begin
                lo_q[i]  <= '0;
                hi_q[i]  <= upper_rst(i);
                ctl_q[i] <= ctrl_rst(i);
            end
        end else begin
            lo_q  <= lo_d;
            hi_q  <= hi_d;
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        case (kind)
            RK_LOWER: cfg_rdata = lo_q[cs_num];
            RK_UPPER: cfg_rdata = hi_q[cs_num];
            RK_CTRL:  cfg_rdata = ctl_q[cs_num];
            default:  cfg_rdata = '0;
        endcase
    end

    generate
        for (genvar g = 0; g < NUM_CS; g++) begin : g_fields
            assign cs_en[g]   = ctl_q[g][EN_BIT];
            assign cs_io[g]   = ctl_q[g][IO_BIT];
            assign cs_wait[g] = ctl_q[g][WAIT_LSB +: WAIT_W];
        end
    endgenerate

    assign lo_bound = lo_q;
    assign hi_bound = hi_q;

endmodule

// File: rtl/csw_decode.sv
module csw_decode
    import csw_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DW     = 8
) (
    input  logic                          bus_req,
    input  logic                          bus_io,
    input  logic [DW-1:0]                 bus_page,
    input  logic [NUM_CS-1:0][DW-1:0]     lo_bound,
    input  logic [NUM_CS-1:0][DW-1:0]     hi_bound,
    input  logic [NUM_CS-1:0]             cs_en,
    input  logic [NUM_CS-1:0]             cs_io,
    input  logic [NUM_CS-1:0][WAIT_W-1:0] cs_wait,
    output logic [NUM_CS-1:0]             sel,
    output logic [WAIT_W-1:0]             wait_sel,
    output logic                          hit_any
);

    logic [NUM_CS-1:0] hit;
    logic [NUM_CS-1:0] first;

    generate
        for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
            assign hit[g] = cs_en[g] && (cs_io[g] == bus_io)
                         && (bus_page >= lo_bound[g])
                         && (bus_page <= hi_bound[g]);
        end
    endgenerate

    assign first = hit & (~hit + NUM_CS'(1));

    always_comb begin
        sel      = bus_req ? first : '0;
        wait_sel = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (sel[i]) wait_sel = wait_sel | cs_wait[i];
        end
    end

    assign hit_any = |sel;

endmodule

// File: rtl/csw_waitctr.sv
module csw_waitctr
    import csw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              hit_any,
    input  logic [WAIT_W-1:0] wait_sel,
    output logic              wait_n
);

    wctr_t st_d, st_q;
    logic  start;
    logic  hold;

    assign start = bus_req && !st_q.req;

    always_comb begin
        st_d.req = bus_req;
        st_d.cnt = '0;
        hold     = 1'b0;
        if (start) begin
            if (hit_any && (wait_sel != '0)) begin
                hold     = 1'b1;
                st_d.cnt = WAIT_W'(wait_sel - WAIT_W'(1));
            end
        end else if (bus_req && (st_q.cnt != '0)) begin
            hold     = 1'b1;
            st_d.cnt = WAIT_W'(st_q.cnt - WAIT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wait_n = !hold;

endmodule

// File: rtl/csel_wait_gen.sv
module csel_wait_gen
    import csw_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DW     = 8,
    localparam int IDX_W = $clog2(NUM_CS) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              bus_req,
    input  logic              bus_io,
    input  logic [DW-1:0]     bus_page,
    output logic [NUM_CS-1:0] cs_n,
    output logic              wait_n
);

    logic [NUM_CS-1:0][DW-1:0]     lo_bound;
    logic [NUM_CS-1:0][DW-1:0]     hi_bound;
    logic [NUM_CS-1:0]             cs_en;
    logic [NUM_CS-1:0]             cs_io;
    logic [NUM_CS-1:0][WAIT_W-1:0] cs_wait;
    logic [NUM_CS-1:0]             sel;
    logic [WAIT_W-1:0]             wait_sel;
    logic                          hit_any;

    csw_regfile #(.NUM_CS(NUM_CS), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .lo_bound  (lo_bound),
        .hi_bound  (hi_bound),
        .cs_en     (cs_en),
        .cs_io     (cs_io),
        .cs_wait   (cs_wait)
    );

    csw_decode #(.NUM_CS(NUM_CS), .DW(DW)) u_dec (
        .bus_req  (bus_req),
        .bus_io   (bus_io),
        .bus_page (bus_page),
        .lo_bound (lo_bound),
        .hi_bound (hi_bound),
        .cs_en    (cs_en),
        .cs_io    (cs_io),
        .cs_wait  (cs_wait),
        .sel      (sel),
        .wait_sel (wait_sel),
        .hit_any  (hit_any)
    );

    csw_waitctr u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .hit_any  (hit_any),
        .wait_sel (wait_sel),
        .wait_n   (wait_n)
    );

    assign cs_n = ~sel;

endmodule

// File: rtl/csw_checker.sv
module csw_checker #(
    parameter int NUM_CS = 4,
    parameter int DW     = 8,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic [DW-1:0]     cfg_wdata,
    input logic [DW-1:0]     cfg_rdata,
    input logic              bus_req,
    input logic [NUM_CS-1:0] cs_n,
    input logic              wait_n
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_one_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_idle_no_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (&cs_n));

    p_idle_no_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> wait_n);

    p_wait_starts_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $fell(wait_n)) |-> (bus_req && !$past(bus_req)));

    p_wait_stays_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && bus_req && $past(bus_req) && $past(wait_n)) |-> wait_n);

    p_ctrl_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx[1:0] == 2'd2) |-> (cfg_rdata[2:0] == 3'd0));

    p_pad_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx[1:0] == 2'd3) |-> (cfg_rdata == '0));

    p_bound_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cfg_we) && ($past(cfg_idx[1:0]) != 2'd2)
         && ($past(cfg_idx[1:0]) != 2'd3) && (cfg_idx == $past(cfg_idx)))
        |-> (cfg_rdata == $past(cfg_wdata)));

endmodule

bind csel_wait_gen csw_checker #(.NUM_CS(NUM_CS), .DW(DW), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .bus_req   (bus_req),
    .cs_n      (cs_n),
    .wait_n    (wait_n)
);

// File: tb/csel_wait_gen_bench.sv
module csel_wait_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_idx = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       bus_req = 1'b0;
    logic       bus_io = 1'b0;
    logic [7:0] bus_page = '0;
    logic [3:0] cs_n;
    logic       wait_n;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    csel_wait_gen u_csel_wait_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_io(bus_io), .bus_page(bus_page), .cs_n(cs_n), .wait_n(wait_n)
    );

    // {page[15:8], io[7], expected select mask[6:3], expected wait[2:0]}
    localparam int NV = 14;
    localparam logic [15:0] VEC [NV] = '{
        {8'h80, 1'b0, 4'b0001, 3'd0},  // lower edge of 0, overlaps 3
        {8'hFF, 1'b0, 4'b0001, 3'd0},  // upper edge of 0
        {8'h90, 1'b0, 4'b0001, 3'd0},
        {8'h7F, 1'b0, 4'b1000, 3'd5},
        {8'h40, 1'b0, 4'b1000, 3'd5},
        {8'h20, 1'b0, 4'b0010, 3'd2},  // lower edge of 1
        {8'h3F, 1'b0, 4'b0010, 3'd2},  // upper edge of 1, overlaps 3
        {8'h1F, 1'b0, 4'b0000, 3'd0},  // only an I/O window here
        {8'h1F, 1'b1, 4'b0100, 3'd1},
        {8'h10, 1'b1, 4'b0100, 3'd1},
        {8'h0F, 1'b1, 4'b0000, 3'd0},
        {8'h20, 1'b1, 4'b0000, 3'd0},  // memory windows, I/O cycle
        {8'h8F, 1'b1, 4'b0000, 3'd0},
        {8'h00, 1'b0, 4'b0000, 3'd0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, input logic [7:0] exp, input string req);
        cfg_idx = idx;
        #1;
        chk(cfg_rdata == exp, req, $sformatf("read idx %0d", idx), cfg_rdata, exp);
    endtask

    // one full access, timed clock by clock, then an idle clock
    task automatic access(input logic [7:0] page, input logic io,
                          input logic [3:0] mask, input int nw, input string req);
        @(negedge clk);
        bus_page = page; bus_io = io; bus_req = 1'b1;
        for (int k = 0; k < 10; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            if (k == 0 || k == 9)
                chk((~cs_n) == mask, req, $sformatf("select page %0h", page), ~cs_n, mask);
            chk(wait_n == !(k < nw), "R8",
                $sformatf("wait clock %0d page %0h", k, page), wait_n, !(k < nw));
        end
        @(negedge clk);
        bus_req = 1'b0;
        #1;
        chk(cs_n == 4'hF, "R7", "select after access", cs_n, 4'hF);
        chk(wait_n == 1'b1, "R9", "wait after access", wait_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(cs_n == 4'hF, "R7", "select in reset", cs_n, 4'hF);
        chk(wait_n == 1'b1, "R8", "wait in reset", wait_n, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents, R2 pad code
        for (int i = 0; i < 4; i++) begin
            rd(4'(i * 4 + 0), 8'h00, "R1");
            rd(4'(i * 4 + 1), (i == 0) ? 8'hFF : 8'h00, "R1");
            rd(4'(i * 4 + 2), (i == 0) ? 8'hE8 : 8'h00, "R1");
            rd(4'(i * 4 + 3), 8'h00, "R2");
        end

        // out of reset select 0 covers all memory with 7 waits
        access(8'h55, 1'b0, 4'b0001, 7, "R1");
        access(8'h55, 1'b1, 4'b0000, 0, "R10");

        // R3 reserved bits, R2 pad write ignored
        wr(4'd6, 8'hFF);
        rd(4'd6, 8'hF8, "R3");
        wr(4'd7, 8'h5A);
        rd(4'd7, 8'h00, "R2");
        rd(4'd6, 8'hF8, "R3");

        // windows: 0 mem 80-FF w0; 1 mem 20-3F w2; 2 io 10-1F w1; 3 mem 30-8F w5
        wr(4'd0, 8'h80); wr(4'd2, 8'h08);
        wr(4'd4, 8'h20); wr(4'd5, 8'h3F); wr(4'd6, 8'h48);
        wr(4'd8, 8'h10); wr(4'd9, 8'h1F); wr(4'd10, 8'h38);
        wr(4'd12, 8'h30); wr(4'd13, 8'h8F); wr(4'd14, 8'hA8);
        rd(4'd13, 8'h8F, "R2");
        rd(4'd14, 8'hA8, "R3");

        for (int v = 0; v < NV; v++) begin
            access(VEC[v][15:8], VEC[v][7], VEC[v][6:3], int'(VEC[v][2:0]),
                   (VEC[v][6:3] == 4'b0) ? "R5" : "R4 R6");
        end

        // R5 disabled window never fires
        wr(4'd14, 8'hA0);
        access(8'h40, 1'b0, 4'b0000, 0, "R5");

        // R8 every wait count
        for (int w = 0; w < 8; w++) begin
            wr(4'd14, 8'((w << 5) | 8'h08));
            access(8'h40, 1'b0, 4'b1000, w, "R8");
        end

        // R9 abandoned access, then fresh count
        @(negedge clk);
        bus_page = 8'h40; bus_io = 1'b0; bus_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(wait_n == 1'b0, "R9", "wait mid access", wait_n, 0);
        bus_req = 1'b0;
        #1;
        chk(wait_n == 1'b1, "R9", "wait on abandon", wait_n, 1);
        chk(cs_n == 4'hF, "R7", "select on abandon", cs_n, 4'hF);
        access(8'h40, 1'b0, 4'b1000, 7, "R9");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule